// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the power control register of an 8-bit microcontroller and turns its mode bits into clock enables. Software writes one byte to a fixed special-function-register address to request a low-power state. In idle, only the processor clock enable drops and the peripheral clocks keep running. In power-down, every clock enable drops and the oscillator is told to stop. The register also keeps a baud-rate doubling flag and two general-purpose flags; the block only stores them, and the doubling flag is exported for the serial port.

The block itself runs from the free-running clock. It can therefore take an enabled interrupt request while the gated clocks are off. Such a request clears both mode bits, and normal clocking resumes on the next cycle. A 2-bit status output reports the current mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous active-low reset clears the whole register to 0x00. The mode is then run (code 00), `cpu_clk_en` and `per_clk_en` are 1, `osc_stop` is 0 and `baud_dbl` is 0.
- R2: A byte write (`sfr_wr`=1, `sfr_bit`=0) to address 0x87 stores the data bits 7, 3, 2, 1 and 0. Bits 6 to 4 are not stored and always read as 0, so a read returns the written value AND 0x8F.
- R3: A write is ignored if `sfr_bit`=1 or if the address is not 0x87. A read under the same conditions returns 0x00.
- R4: A byte read (`sfr_rd`=1, `sfr_bit`=0) of address 0x87 returns the register on `sfr_rdata` in the same cycle. The bit positions are: 7 baud double, 3 flag 1, 2 flag 0, 1 power-down, 0 idle.
- R5: With bit 0 set and bit 1 clear, the mode is idle (code 01): `cpu_clk_en`=0, `per_clk_en`=1, `osc_stop`=0.
- R6: With bit 1 set, the mode is power-down (code 10): `cpu_clk_en`=0, `per_clk_en`=0, `osc_stop`=1.
- R7: If bits 1 and 0 are both set, including by one write, power-down wins.
- R8: When `irq_wake` is 1 at a clock edge, bits 1 and 0 are cleared at that edge and the other bits are kept. This also holds against a write in the same cycle, in which case the other written bits are still stored.
- R9: Bits 7, 3 and 2 do not affect the clock enables or the mode. `baud_dbl` follows bit 7.
- R10: A new mode first shows on the outputs after the clock edge that takes the write. During the write cycle itself the outputs still show the previous mode. The mode code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | Write strobe |
| sfr_rd | input | 1 | Read strobe |
| sfr_bit | input | 1 | Access is bit-level (rejected) |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, 0 when not selected |
| irq_wake | input | 1 | Enabled interrupt request |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Timer, serial and interrupt clock enable |
| osc_stop | output | 1 | Stop the oscillator |
| baud_dbl | output | 1 | Stored baud-doubling flag |
| mode | output | 2 | 00 run, 01 idle, 10 power-down |

## Verification
On every cycle the assertions check four things:
- the clock enables agree with the reported mode, and power-down stops everything;
- the code 11 never appears;
- a wake request always returns the block to run on the next cycle;
- a rejected bit-level write leaves the outputs unchanged.

Only the bench's scenarios show the following:
- that every one of the 256 byte values maps to the right stored image and mode;
- that the reserved bits read back as 0;
- that the flags survive a wake;
- that a new mode appears exactly one edge after its write.

// File: rtl/pwr_pkg.sv
// Package: shared encodings for the low-power mode controller.
// Assumes an 8-bit SFR data path; the bit positions are the ones software uses.
package pwr_pkg;
    localparam int SFR_W    = 8;
    localparam int BIT_IDL  = 0;
    localparam int BIT_PD   = 1;
    localparam int BIT_GF0  = 2;
    localparam int BIT_GF1  = 3;
    localparam int BIT_SMOD = 7;
    // Bits that are backed by storage; the rest read as zero.
    localparam logic [SFR_W-1:0] IMPL_MASK = 8'h8F;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_PD   = 2'b10
    } pwr_mode_e;
endpackage

// File: rtl/pwr_reg.sv
// Module: pwr_reg
// Holds the power control byte. A write replaces the implemented bits. A wake
// request clears the two mode bits and takes priority over a write to them.
// Assumes clk is free-running, so a wake is seen even while the gated clocks are off.
module pwr_reg
    import pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SFR_W-1:0] wdata,
    input  logic             wake,
    output logic [SFR_W-1:0] q
);
    logic [SFR_W-1:0] nxt;

    // Next value: the write image with the reserved bits masked, then the wake clears the mode bits.
    always_comb begin
        nxt = wr_en ? (wdata & IMPL_MASK) : q;
        if (wake) begin
            nxt[BIT_PD]  = 1'b0;
            nxt[BIT_IDL] = 1'b0;
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/pwr_gate.sv
// Module: pwr_gate
// Decodes the stored mode bits into the mode code and the clock and oscillator
// controls. Power-down has precedence over idle. Purely combinational.
module pwr_gate
    import pwr_pkg::*;
(
    input  logic       pd,
    input  logic       idl,
    output logic [1:0] mode,
    output logic       cpu_en,
    output logic       per_en,
    output logic       osc_off
);
    // Choose the mode by priority, then derive the enables from it.
    always_comb begin
        if (pd)       mode = MODE_PD;
        else if (idl) mode = MODE_IDLE;
        else          mode = MODE_RUN;
        cpu_en  = (mode == MODE_RUN);
        per_en  = (mode != MODE_PD);
        osc_off = (mode == MODE_PD);
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Power control SFR with clock-gating outputs. Decodes the SFR bus at REG_ADDR
// and accepts byte access only. Stores the register and drives the enables.
// Assumes a single-cycle SFR bus whose read data is combinational.
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic              sfr_rd,
    input  logic              sfr_bit,
    input  logic [SFR_W-1:0]  sfr_wdata,
    output logic [SFR_W-1:0]  sfr_rdata,
    input  logic              irq_wake,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_stop,
    output logic              baud_dbl,
    output logic [1:0]        mode
);
    logic             sel;
    logic [SFR_W-1:0] reg_q;

    // Byte-access select at the register address.
    always_comb sel = (sfr_addr == REG_ADDR) && !sfr_bit;

    pwr_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel && sfr_wr),
        .wdata (sfr_wdata),
        .wake  (irq_wake),
        .q     (reg_q)
    );

    pwr_gate u_gate (
        .pd      (reg_q[BIT_PD]),
        .idl     (reg_q[BIT_IDL]),
        .mode    (mode),
        .cpu_en  (cpu_clk_en),
        .per_en  (per_clk_en),
        .osc_off (osc_stop)
    );

    // Read mux: the register image when selected, zero otherwise.
    always_comb sfr_rdata = (sel && sfr_rd) ? reg_q : '0;

    // The baud flag is only exported.
    always_comb baud_dbl = reg_q[BIT_SMOD];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Module: pwr_mode_ctrl_chk
// Checker bound to pwr_mode_ctrl. Watches only its ports and checks the mode
// and enable relations on every clock cycle.
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] sfr_addr,
    input logic       sfr_wr,
    input logic       sfr_bit,
    input logic [7:0] sfr_wdata,
    input logic       irq_wake,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_stop,
    input logic       baud_dbl,
    input logic [1:0] mode
);
    // R6
    pd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |-> (!cpu_clk_en && !per_clk_en && mode == 2'b10));

    // R5
    idle_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_clk_en && !cpu_clk_en) |-> (mode == 2'b01 && !osc_stop));

    // R10
    no_code3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

    // R8
    wake_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wake |=> (mode == 2'b00 && cpu_clk_en));

    // R3
    bit_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_bit && !irq_wake) |=> ($stable(mode) && $stable(baud_dbl)));

    // R9
    flags_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && !sfr_bit && sfr_addr == 8'h87 && sfr_wdata[1:0] == 2'b00)
        |=> (mode == 2'b00 && cpu_clk_en && per_clk_en));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_addr   (sfr_addr),
    .sfr_wr     (sfr_wr),
    .sfr_bit    (sfr_bit),
    .sfr_wdata  (sfr_wdata),
    .irq_wake   (irq_wake),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_stop   (osc_stop),
    .baud_dbl   (baud_dbl),
    .mode       (mode)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [7:0] sfr_addr = 0;
    logic       sfr_wr = 0, sfr_rd = 0, sfr_bit = 0, irq_wake = 0;
    logic [7:0] sfr_wdata = 0;
    logic [7:0] sfr_rdata;
    logic       cpu_clk_en, per_clk_en, osc_stop, baud_dbl;
    logic [1:0] mode;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_rd(sfr_rd), .sfr_bit(sfr_bit), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .irq_wake(irq_wake), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_stop(osc_stop), .baud_dbl(baud_dbl),
        .mode(mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus write, optionally with a wake in the same cycle.
    task automatic wr(input logic [7:0] a, input logic b, input logic [7:0] d, input logic wk);
        @(negedge clk);
        sfr_addr = a; sfr_bit = b; sfr_wdata = d; sfr_wr = 1; irq_wake = wk;
        @(posedge clk); #1;
        sfr_wr = 0; irq_wake = 0; sfr_bit = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic b, output logic [7:0] v);
        @(negedge clk);
        sfr_addr = a; sfr_bit = b; sfr_rd = 1;
        #1 v = sfr_rdata;
        sfr_rd = 0; sfr_bit = 0;
    endtask

    task automatic wake();
        @(negedge clk); irq_wake = 1;
        @(posedge clk); #1 irq_wake = 0;
    endtask

    // Compare every output with the mode expected from the stored byte.
    task automatic chk_outs(input string req, input logic [7:0] img);
        logic [1:0] em;
        em = img[1] ? 2'b10 : (img[0] ? 2'b01 : 2'b00);
        chk({req, " mode"}, {6'd0, mode}, {6'd0, em});
        chk({req, " cpu_en"}, {7'd0, cpu_clk_en}, {7'd0, em == 2'b00});
        chk({req, " per_en"}, {7'd0, per_clk_en}, {7'd0, em != 2'b10});
        chk({req, " osc"}, {7'd0, osc_stop}, {7'd0, em == 2'b10});
        chk("R9 baud", {7'd0, baud_dbl}, {7'd0, img[7]});
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(8'h87, 0, v); chk("R1 reg", v, 8'h00);
        chk_outs("R1", 8'h00);

        // R2 R4 R5 R6 R7 R9 R8: sweep all byte values
        for (int i = 0; i < 256; i++) begin
            wr(8'h87, 0, 8'(i), 0);
            rd(8'h87, 0, v); chk("R2 R4 readback", v, 8'(i) & 8'h8F);
            chk_outs("R5 R6 R7", 8'(i) & 8'h8F);
            wake();
            rd(8'h87, 0, v); chk("R8 wake keeps flags", v, 8'(i) & 8'h8C);
            chk_outs("R8", 8'(i) & 8'h8C);
        end

        // R10: the write cycle itself still shows run
        @(negedge clk);
        sfr_addr = 8'h87; sfr_wdata = 8'h01; sfr_wr = 1;
        #1 chk("R10 pre-edge mode", {6'd0, mode}, 8'h00);
        @(posedge clk); #1 sfr_wr = 0;
        chk("R10 post-edge mode", {6'd0, mode}, 8'h01);
        wake();

        // R8: wake beats a simultaneous write of the mode bits
        wr(8'h87, 0, 8'h8F, 1);
        rd(8'h87, 0, v); chk("R8 wake vs write", v, 8'h8C);
        chk_outs("R8 wake vs write", 8'h8C);

        // R3: rejected accesses
        wr(8'h87, 0, 8'h84, 0);
        wr(8'h87, 1, 8'h03, 0);
        rd(8'h87, 0, v); chk("R3 bit write", v, 8'h84);
        chk_outs("R3", 8'h84);
        for (int a = 0; a < 256; a += 17) begin
            if (a != 8'h87) begin
                wr(8'(a), 0, 8'hFF, 0);
                rd(8'(a), 0, v); chk("R3 other addr read", v, 8'h00);
            end
        end
        wr(8'h86, 0, 8'hFF, 0); wr(8'h88, 0, 8'hFF, 0);
        rd(8'h87, 0, v); chk("R3 other addr write", v, 8'h84);
        rd(8'h87, 1, v); chk("R3 bit read", v, 8'h00);

        // R1: reset from power-down
        wr(8'h87, 0, 8'h8E, 0);
        chk_outs("R6", 8'h8E);
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        rd(8'h87, 0, v); chk("R1 reset from pd", v, 8'h00);
        chk_outs("R1 after pd", 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule